// File: doc/BRIEF.md
# Banked RAM paging and remap controller

This block lets a Z80-class home computer address 128 KB of RAM as eight 16 KB pages. The RAM is split into two DRAM groups of four pages each. One group sits on the video bus and the CPU and the video chip share it. The other group is reached only by the CPU. The CPU writes a six-bit paging register through an I/O port. That register chooses the page seen in the top 16 KB slot, which of two screen pages the video chip shows, and which of two 16 KB ROM images is enabled. A lock bit freezes the register until the next reset.

For every memory cycle the block decides who owns it. If the memory-request strobe is active, the CPU owns the cycle. If it is inactive, the cycle is a video fetch, because the video chip halts the CPU clock while it reads. From that decision it drives four things. The first is the remapped A15, which is the only A15 the video chip ever sees. The second is an extra row-address bit for each DRAM group. The third is the address-multiplexer select for each group. The last is the ROM bank line. All outputs except the register are combinational.

Top module: `paging_ctl`

## Requirements
- R1: An active-low reset clears all six register bits, including the lock bit.
- R2: On a rising clock edge the register loads d[5:0] if all of these hold: iorq_n and wr_n are low, m1_n is high, a15 and a1 are low, and bit 5 is clear. Bits 2:0 are the top-slot page, bit 3 is the screen choice, bit 4 is the ROM bank and bit 5 is the lock.
- R3: An I/O cycle with a15 high, a1 high, m1_n low or wr_n high leaves the register unchanged.
- R4: While register bit 5 is set, every port write is ignored until reset.
- R5: In a CPU cycle (mreq_n low) the slot {a15,a14} picks the page. Slot 00 is ROM: both selects low, both extra row bits low and new_a15 low. Slot 01 is page 5, slot 10 is page 2 and slot 11 is the page in register bits 2:0.
- R6: For a CPU RAM page p, odd pages belong to the video group and even pages to the upper group. The owning group's select is high and its extra row bit equals p[2]. The other group's select and row bit are low. new_a15 equals p[1].
- R7: In a video fetch (mreq_n high) the shown page is 5 if register bit 3 is 0 and 7 if it is 1, whatever a15 and a14 are. Both selects are low, vram_a7 is 1, uram_a7 is 0 and new_a15 equals bit 3.
- R8: rom_a14 always equals register bit 4.
- R9: The two multiplexer selects are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples port writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreq_n | input | 1 | Memory-request strobe; low marks a CPU cycle |
| iorq_n | input | 1 | I/O-request strobe |
| wr_n | input | 1 | Write strobe |
| m1_n | input | 1 | Opcode-fetch strobe; low with iorq_n marks an interrupt acknowledge |
| a15 | input | 1 | CPU address bit 15 |
| a14 | input | 1 | CPU address bit 14 |
| a1 | input | 1 | CPU address bit 1 |
| d | input | 6 | CPU data bits 5:0 |
| new_a15 | output | 1 | Remapped A15 for the video chip and the upper multiplexer |
| vram_a7 | output | 1 | Extra row bit of the video-group DRAM |
| uram_a7 | output | 1 | Extra row bit of the upper-group DRAM |
| vram_sel | output | 1 | Video-group multiplexer takes the CPU address |
| uram_sel | output | 1 | Upper-group multiplexer takes the CPU address |
| rom_a14 | output | 1 | ROM bank address line |

## Verification
The assertions check these rules on every cycle: the two selects are never both high, and a video fetch always drives the screen pattern. They also check that the register takes the data bus only on a qualified port write, that a set lock or an interrupt acknowledge keeps it frozen, and that the ROM line moves only after a write. The mapping itself can only be shown by the bench's scenarios. They cover each slot under every register value, each rejected decode variant, and the way a reset clears a lock.

// File: rtl/paging_ctl.sv
module paging_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mreq_n,
  input  logic       iorq_n,
  input  logic       wr_n,
  input  logic       m1_n,
  input  logic       a15,
  input  logic       a14,
  input  logic       a1,
  input  logic [5:0] d,
  output logic       new_a15,
  output logic       vram_a7,
  output logic       uram_a7,
  output logic       vram_sel,
  output logic       uram_sel,
  output logic       rom_a14
);
  localparam logic [2:0] SLOT1_PAGE = 3'd5;
  localparam logic [2:0] SLOT2_PAGE = 3'd2;

  logic [5:0] pg_q;
  logic       port_wr;
  logic [2:0] cpu_page;
  logic       rom_slot;

  assign port_wr = !iorq_n && !wr_n && m1_n && !a15 && !a1 && !pg_q[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pg_q <= '0;
    else if (port_wr) pg_q <= d;
  end

  assign rom_slot = !a15 && !a14;

  always_comb begin
    unique case ({a15, a14})
      2'b01:   cpu_page = SLOT1_PAGE;
      2'b10:   cpu_page = SLOT2_PAGE;
      2'b11:   cpu_page = pg_q[2:0];
      default: cpu_page = 3'd0;
    endcase
  end

  always_comb begin
    if (mreq_n) begin
      new_a15  = pg_q[3];
      vram_a7  = 1'b1;
      uram_a7  = 1'b0;
      vram_sel = 1'b0;
      uram_sel = 1'b0;
    end else if (rom_slot) begin
      new_a15  = 1'b0;
      vram_a7  = 1'b0;
      uram_a7  = 1'b0;
      vram_sel = 1'b0;
      uram_sel = 1'b0;
    end else begin
      new_a15  = cpu_page[1];
      vram_a7  = cpu_page[0] & cpu_page[2];
      uram_a7  = !cpu_page[0] & cpu_page[2];
      vram_sel = cpu_page[0];
      uram_sel = !cpu_page[0];
    end
  end

  assign rom_a14 = pg_q[4];
endmodule

// File: rtl/paging_ctl_chk.sv
module paging_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mreq_n,
  input logic       iorq_n,
  input logic       wr_n,
  input logic       m1_n,
  input logic       a15,
  input logic       a1,
  input logic [5:0] d,
  input logic [5:0] pg_q,
  input logic       vram_a7,
  input logic       uram_a7,
  input logic       vram_sel,
  input logic       uram_sel,
  input logic       rom_a14
);
  logic wr_try;
  assign wr_try = !iorq_n && !wr_n && m1_n && !a15 && !a1;

  // R9
  a_r9_sel_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(vram_sel && uram_sel));

  // R7
  a_r7_video_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_n |-> (!vram_sel && !uram_sel && vram_a7 && !uram_a7));

  // R2
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_try && !pg_q[5]) |=> (pg_q == $past(d)));

  // R4
  a_r4_locked: assert property (@(posedge clk) disable iff (!rst_n)
    pg_q[5] |=> $stable(pg_q));

  // R3
  a_r3_no_decode: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_try |=> $stable(pg_q));

  // R8
  a_r8_rom_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_try |=> $stable(rom_a14));
endmodule

bind paging_ctl paging_ctl_chk chk (
  .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .iorq_n(iorq_n), .wr_n(wr_n),
  .m1_n(m1_n), .a15(a15), .a1(a1), .d(d), .pg_q(pg_q),
  .vram_a7(vram_a7), .uram_a7(uram_a7), .vram_sel(vram_sel),
  .uram_sel(uram_sel), .rom_a14(rom_a14)
);

// File: tb/paging_ctl_test.sv
`timescale 1ns/1ps
module paging_ctl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mreq_n = 1'b1, iorq_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
  logic a15 = 1'b0, a14 = 1'b0, a1 = 1'b0;
  logic [5:0] d = '0;
  logic new_a15, vram_a7, uram_a7, vram_sel, uram_sel, rom_a14;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  paging_ctl uut (
    .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .iorq_n(iorq_n), .wr_n(wr_n),
    .m1_n(m1_n), .a15(a15), .a14(a14), .a1(a1), .d(d),
    .new_a15(new_a15), .vram_a7(vram_a7), .uram_a7(uram_a7),
    .vram_sel(vram_sel), .uram_sel(uram_sel), .rom_a14(rom_a14)
  );

  function automatic logic [5:0] model(input logic [5:0] r, input logic vid,
                                       input logic [1:0] slot);
    logic [2:0] p;
    if (vid) return {r[3], 1'b1, 1'b0, 1'b0, 1'b0, r[4]};
    if (slot == 2'b00) return {5'b0, r[4]};
    p = (slot == 2'b01) ? 3'd5 : (slot == 2'b10) ? 3'd2 : r[2:0];
    if (p[0]) return {p[1], p[2], 1'b0, 1'b1, 1'b0, r[4]};
    return {p[1], 1'b0, p[2], 1'b0, 1'b1, r[4]};
  endfunction

  task automatic chk(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {new_a15, vram_a7, uram_a7, vram_sel, uram_sel, rom_a14};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    mreq_n = 1'b1; iorq_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic io_write(input logic [5:0] v, input logic ha15, input logic ha1,
                          input logic hm1, input logic hwr);
    @(negedge clk);
    mreq_n = 1'b1; iorq_n = 1'b0; wr_n = hwr; m1_n = hm1;
    a15 = ha15; a1 = ha1; d = v;
    @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1; a15 = 1'b0; a1 = 1'b0;
    @(negedge clk);
  endtask

  task automatic probe(input string req, input logic [5:0] r, input logic vid);
    for (int s = 0; s < 4; s++) begin
      mreq_n = vid; {a15, a14} = 2'(s);
      #1;
      chk(req, model(r, vid, 2'(s)));
    end
    mreq_n = 1'b1; a15 = 1'b0; a14 = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    probe("R1", 6'd0, 1'b0);
  endtask

  task automatic t_all_values();
    for (int v = 0; v < 64; v++) begin
      do_reset();
      io_write(6'(v), 1'b0, 1'b0, 1'b1, 1'b0);
      probe("R5_R6_R8", 6'(v), 1'b0);
      probe("R7", 6'(v), 1'b1);
      if (v >= 32) begin
        io_write(~6'(v), 1'b0, 1'b0, 1'b1, 1'b0);
        probe("R4", 6'(v), 1'b0);
      end
    end
  endtask

  task automatic t_bad_decode();
    do_reset();
    io_write(6'h1F, 1'b1, 1'b0, 1'b1, 1'b0);
    probe("R3", 6'd0, 1'b0);
    io_write(6'h1F, 1'b0, 1'b1, 1'b1, 1'b0);
    probe("R3", 6'd0, 1'b0);
    io_write(6'h1F, 1'b0, 1'b0, 1'b0, 1'b0);
    probe("R3", 6'd0, 1'b0);
    io_write(6'h1F, 1'b0, 1'b0, 1'b1, 1'b1);
    probe("R3", 6'd0, 1'b0);
    io_write(6'h1B, 1'b0, 1'b0, 1'b1, 1'b0);
    probe("R2", 6'h1B, 1'b0);
  endtask

  task automatic t_unlock_by_reset();
    do_reset();
    io_write(6'h3F, 1'b0, 1'b0, 1'b1, 1'b0);
    do_reset();
    probe("R1", 6'd0, 1'b0);
    io_write(6'h0E, 1'b0, 1'b0, 1'b1, 1'b0);
    probe("R4", 6'h0E, 1'b0);
  endtask

  initial begin
    t_reset();
    t_all_values();
    t_bad_decode();
    t_unlock_by_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule